// File: doc/BRIEF.md
# PCI Memory and I/O Target

This block is a 32-bit target on a PCI-style shared address/data bus. It answers a fixed memory window, a fixed I/O window and a one-word identity register in configuration space. Reads and writes, single or burst, go to a small flop-based word array. On the first clock of a transaction the block decodes the command and address. It claims the cycle by pulling DEVSEL# low on the next clock and then moves one 32-bit word on every clock where both ready signals are low.

The I/O window is an alias of the lowest words of the array. The memory window may be wider than the array. A burst that walks past the end of the array, or an access that starts beyond it, is ended with a disconnect instead of being wrapped. The shared AD lines are split into an input, an output and an output enable, so that the pad ring can build the tri-state driver.

Top module: `pci_mem_target`

## Requirements
- R1: While reset is active and on the first clock after it, DEVSEL#, TRDY# and STOP# are high and the AD output enable is low.
- R2: Memory reads use C/BE# codes 0110, 1100 and 1110 at an address inside the memory window. They are claimed with DEVSEL# low on the clock after the address phase. That clock is a turnaround with TRDY# high and AD not driven, and the data word is then presented with TRDY# low.
- R3: Memory writes use codes 0111 and 1111 and are claimed with TRDY# low on the clock after the address phase. C/BE# bit i low writes byte lane AD[8i+7:8i], and a high bit leaves that byte unchanged.
- R4: A data phase completes only on a clock edge where IRDY# and TRDY# are both low. While IRDY# is high, read data is held, nothing is written and the address does not advance.
- R5: Each completed data phase moves the word address up by 4, so a burst fills or reads consecutive words.
- R6: When FRAME# is high during the completing data phase, DEVSEL# and TRDY# go high on the next clock.
- R7: I/O read (0010) and I/O write (0011) inside the I/O window reach array word (address minus I/O base)/4.
- R8: Configuration read (1010) and write (1011) are claimed only when IDSEL is high and AD[1:0] is 00. A read at register offset 0 returns the device ID and other offsets return zero. Configuration writes change nothing.
- R9: Reserved and unsupported codes (0100, 0101, 1000, 1001 among them) are not claimed. Addresses outside both windows are not claimed either, and such cycles leave DEVSEL# high and the array unchanged.
- R10: If the word to transfer next lies beyond the array (or beyond the I/O window), the target holds STOP# low with TRDY# high and DEVSEL# low. It releases all three on the clock after it samples FRAME# high, and no data moves in that phase.
- R11: The AD output enable is high only in claimed read data phases, never during writes or the read turnaround.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Transaction framing from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| idsel | input | 1 | Configuration select for this device |
| ad_i | input | 32 | AD lines as seen on the bus |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in data phases |
| ad_o | output | 32 | Read data driven onto AD |
| ad_oe | output | 1 | Enable for the AD drivers |
| devsel_n | output | 1 | Cycle claimed, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Disconnect request, active low |

## Verification
The bench builds the target with an 8-word array inside a 16-word memory window and a 4-word I/O window, with non-zero bases. With these sizes a short burst already runs off the end of the array or the I/O alias, so the disconnect path is reached. A start address above the array but still inside the window covers the case where a cycle is claimed but carries no data. The small array also lets the bench follow every word it writes through both windows.

// File: rtl/pci_mem_target.sv
module pci_mem_target #(
  parameter logic [31:0] MEM_BASE      = 32'h8000_0000,
  parameter int          MEM_WIN_WORDS = 64,
  parameter int          MEM_WORDS     = 32,
  parameter logic [31:0] IO_BASE       = 32'h0000_0400,
  parameter int          IO_WORDS      = 8,
  parameter int          CFG_WORDS     = 64,
  parameter logic [31:0] DEV_ID        = 32'h1D0C_5A17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [31:0] ad_i,
  input  logic [3:0]  cbe_n,
  output logic [31:0] ad_o,
  output logic        ad_oe,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic        stop_n
);

  localparam int          AW       = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;
  localparam logic [31:0] MEM_MASK = ~(32'(MEM_WIN_WORDS * 4) - 32'd1);
  localparam logic [31:0] IO_MASK  = ~(32'(IO_WORDS * 4) - 32'd1);
  localparam logic [29:0] MEM_LIM  = 30'(MEM_WORDS);
  localparam logic [29:0] IO_LIM   = 30'(IO_WORDS);
  localparam logic [29:0] CFG_LIM  = 30'(CFG_WORDS);

  typedef enum logic [2:0] {S_IDLE, S_SKIP, S_TURN, S_DATA, S_STOP} state_t;
  typedef enum logic [1:0] {SP_MEM, SP_IO, SP_CFG} space_t;

  state_t      st;
  space_t      sp, a_sp;
  logic        rd, a_rd, hit;
  logic [29:0] idx, a_idx, lim, a_lim, nxt;
  logic [31:0] mem [MEM_WORDS];
  logic [31:0] moff, ioff;

  wire mem_rd = cbe_n inside {4'b0110, 4'b1100, 4'b1110};
  wire mem_wr = cbe_n inside {4'b0111, 4'b1111};
  wire io_cmd = cbe_n inside {4'b0010, 4'b0011};
  wire cf_cmd = cbe_n inside {4'b1010, 4'b1011};

  assign moff = ad_i & ~MEM_MASK;
  assign ioff = ad_i & ~IO_MASK;
  assign nxt  = idx + 30'd1;

  always_comb begin
    hit   = 1'b0;
    a_sp  = SP_MEM;
    a_idx = moff[31:2];
    a_lim = MEM_LIM;
    a_rd  = mem_rd || cbe_n == 4'b0010 || cbe_n == 4'b1010;
    if ((mem_rd || mem_wr) && (ad_i & MEM_MASK) == MEM_BASE) begin
      hit = 1'b1;
    end else if (io_cmd && (ad_i & IO_MASK) == IO_BASE) begin
      hit   = 1'b1;
      a_sp  = SP_IO;
      a_idx = ioff[31:2];
      a_lim = IO_LIM;
    end else if (cf_cmd && idsel && ad_i[1:0] == 2'b00) begin
      hit   = 1'b1;
      a_sp  = SP_CFG;
      a_idx = {24'd0, ad_i[7:2]};
      a_lim = CFG_LIM;
    end
  end

  function automatic logic [31:0] fetch(input space_t s, input logic [29:0] i);
    if (s == SP_CFG)   return (i == 30'd0) ? DEV_ID : 32'h0;
    if (i < MEM_LIM)   return mem[i[AW-1:0]];
    return 32'h0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sp       <= SP_MEM;
      rd       <= 1'b0;
      idx      <= '0;
      lim      <= '0;
      ad_o     <= '0;
      ad_oe    <= 1'b0;
      devsel_n <= 1'b1;
      trdy_n   <= 1'b1;
      stop_n   <= 1'b1;
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
    end else begin
      case (st)
        S_IDLE: if (!frame_n) begin
          if (hit) begin
            sp       <= a_sp;
            rd       <= a_rd;
            idx      <= a_idx;
            lim      <= a_lim;
            devsel_n <= 1'b0;
            if (a_idx >= a_lim) begin
              stop_n <= 1'b0;
              st     <= S_STOP;
            end else if (a_rd) begin
              st <= S_TURN;
            end else begin
              trdy_n <= 1'b0;
              st     <= S_DATA;
            end
          end else begin
            st <= S_SKIP;
          end
        end
        S_SKIP: if (frame_n) st <= S_IDLE;
        S_TURN: begin
          ad_o   <= fetch(sp, idx);
          ad_oe  <= 1'b1;
          trdy_n <= 1'b0;
          st     <= S_DATA;
        end
        S_DATA: if (!irdy_n) begin
          if (!rd && sp != SP_CFG && idx < MEM_LIM)
            for (int b = 0; b < 4; b++)
              if (!cbe_n[b]) mem[idx[AW-1:0]][8*b +: 8] <= ad_i[8*b +: 8];
          idx <= nxt;
          if (frame_n) begin
            ad_oe    <= 1'b0;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            st       <= S_IDLE;
          end else if (nxt >= lim) begin
            trdy_n <= 1'b1;
            stop_n <= 1'b0;
            st     <= S_STOP;
          end else if (rd) begin
            ad_o <= fetch(sp, nxt);
          end
        end
        S_STOP: if (frame_n) begin
          ad_oe    <= 1'b0;
          devsel_n <= 1'b1;
          trdy_n   <= 1'b1;
          stop_n   <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_trdy_needs_devsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !devsel_n);

  assert_stop_without_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> (trdy_n && !devsel_n));

  assert_read_turnaround_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(devsel_n) && rd && stop_n) |-> (trdy_n && !ad_oe));

  assert_last_phase_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n));

  assert_drive_when_claimed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !devsel_n);

  assert_wait_holds_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n && ad_oe) |=> $stable(ad_o));

endmodule

// File: tb/sim_pci_mem_target.sv
module sim_pci_mem_target;
  localparam logic [31:0] MB  = 32'h1000_0000;
  localparam logic [31:0] IB  = 32'h0000_0300;
  localparam logic [31:0] DID = 32'hC0FF_EE01;
  localparam int NV = 20;

  typedef struct packed {
    logic [3:0]  cmd;
    logic        sel;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  be;
    logic        claim;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{4'h7, 1'b0, MB,         32'h1122_3344, 4'h0, 1'b1},  // R3 full word
    '{4'h6, 1'b0, MB,         32'h1122_3344, 4'h0, 1'b1},  // R2
    '{4'h7, 1'b0, MB + 4,     32'hAABB_CCDD, 4'hA, 1'b1},  // R3 lanes 0,2
    '{4'hC, 1'b0, MB + 4,     32'h00BB_00DD, 4'h0, 1'b1},  // R2 read multiple
    '{4'hF, 1'b0, MB + 4,     32'hFFFF_FFFF, 4'hC, 1'b1},  // R3 write+invalidate lanes 0,1
    '{4'hE, 1'b0, MB + 4,     32'h00BB_FFFF, 4'h0, 1'b1},  // R2 read line
    '{4'h3, 1'b0, IB + 4,     32'h1234_5678, 4'h0, 1'b1},  // R7 io write word 1
    '{4'h6, 1'b0, MB + 4,     32'h1234_5678, 4'h0, 1'b1},  // R7 alias seen in memory
    '{4'h2, 1'b0, IB,         32'h1122_3344, 4'h0, 1'b1},  // R7 io read word 0
    '{4'hA, 1'b1, 32'h0,      DID,           4'h0, 1'b1},  // R8 id register
    '{4'hA, 1'b0, 32'h0,      32'h0,         4'h0, 1'b0},  // R8 no idsel
    '{4'h4, 1'b0, MB,         32'h0,         4'h0, 1'b0},  // R9 reserved
    '{4'h6, 1'b0, MB + 64,    32'h0,         4'h0, 1'b0},  // R9 outside window
    '{4'hB, 1'b1, 32'h0,      32'h0,         4'h0, 1'b1},  // R8 config write
    '{4'hA, 1'b1, 32'h0,      DID,           4'h0, 1'b1},  // R8 id unchanged
    '{4'h8, 1'b0, MB,         32'hDEAD_BEEF, 4'h0, 1'b0},  // R9 reserved write
    '{4'h6, 1'b0, MB,         32'h1122_3344, 4'h0, 1'b1},  // R9 word untouched
    '{4'h3, 1'b0, IB + 16,    32'h0,         4'h0, 1'b0},  // R9 io outside window
    '{4'hA, 1'b1, 32'h4,      32'h0,         4'h0, 1'b1},  // R8 other offset
    '{4'h9, 1'b0, MB,         32'h0,         4'h0, 1'b0}   // R9 reserved
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_n = '0;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n, trdy_n, stop_n;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  pci_mem_target #(.MEM_BASE(MB), .MEM_WIN_WORDS(16), .MEM_WORDS(8), .IO_BASE(IB),
                   .IO_WORDS(4), .CFG_WORDS(64), .DEV_ID(DID)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .ad_i(ad_i), .cbe_n(cbe_n), .ad_o(ad_o), .ad_oe(ad_oe), .devsel_n(devsel_n),
    .trdy_n(trdy_n), .stop_n(stop_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addr_ph(input logic [3:0] c, input logic s, input logic [31:0] a);
    frame_n = 1'b0; irdy_n = 1'b1; idsel = s; cbe_n = c; ad_i = a;
    @(negedge clk);
    idsel = 1'b0;
  endtask

  task automatic wr_ph(input logic [31:0] d, input logic [3:0] be, input logic last);
    chk("R3", trdy_n, 0);
    chk("R11", ad_oe, 0);
    irdy_n = 1'b0; ad_i = d; cbe_n = be; frame_n = last;
    @(negedge clk);
  endtask

  task automatic rd_ph(input logic [31:0] exp, input logic last, input string req);
    chk(req, trdy_n, 0);
    chk("R11", ad_oe, 1);
    chk(req, ad_o, exp);
    irdy_n = 1'b0; frame_n = last; cbe_n = 4'h0;
    @(negedge clk);
  endtask

  task automatic end_chk(input string req);
    chk(req, {devsel_n, trdy_n, stop_n}, 3'b111);
    irdy_n = 1'b1; frame_n = 1'b1; cbe_n = '0; ad_i = '0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1", {devsel_n, trdy_n, stop_n, ad_oe}, 4'b1110);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {devsel_n, trdy_n, stop_n, ad_oe}, 4'b1110);

    for (int i = 0; i < NV; i++) begin
      vec_t  v;
      string rq;
      v = TBL[i];
      if (!v.claim)                               rq = "R9";
      else if (v.cmd == 4'hA || v.cmd == 4'hB)    rq = "R8";
      else if (v.cmd == 4'h2 || v.cmd == 4'h3)    rq = "R7";
      else if (v.cmd == 4'h7 || v.cmd == 4'hF)    rq = "R3";
      else                                        rq = "R2";
      addr_ph(v.cmd, v.sel, v.addr);
      chk(rq, devsel_n, {31'd0, !v.claim});
      if (!v.claim) begin
        frame_n = 1'b1; irdy_n = 1'b0; ad_i = v.data; cbe_n = v.be;
        @(negedge clk);
        chk(rq, {devsel_n, trdy_n}, 2'b11);
        irdy_n = 1'b1;
        @(negedge clk);
      end else if (v.cmd inside {4'h2, 4'h6, 4'hA, 4'hC, 4'hE}) begin
        chk("R2", trdy_n, 1);
        chk("R11", ad_oe, 0);
        @(negedge clk);
        rd_ph(v.data, 1'b1, rq);
        end_chk("R6");
      end else begin
        wr_ph(v.data, v.be, 1'b1);
        end_chk("R6");
      end
    end

    // R5: write burst into words 2..7
    addr_ph(4'h7, 1'b0, MB + 8);
    for (int k = 2; k < 8; k++) wr_ph(32'hA000_0000 + k, 4'h0, k == 7);
    end_chk("R6");

    // R4 R5: read burst with a master wait state
    addr_ph(4'h6, 1'b0, MB + 8);
    chk("R2", {ad_oe, trdy_n}, 2'b01);
    @(negedge clk);
    rd_ph(32'hA000_0002, 1'b0, "R5");
    irdy_n = 1'b1;
    chk("R5", ad_o, 32'hA000_0003);
    @(negedge clk);
    chk("R4", ad_o, 32'hA000_0003);
    rd_ph(32'hA000_0003, 1'b0, "R4");
    rd_ph(32'hA000_0004, 1'b1, "R5");
    end_chk("R6");

    // R10: burst runs past the array end
    addr_ph(4'h6, 1'b0, MB + 24);
    @(negedge clk);
    rd_ph(32'hA000_0006, 1'b0, "R5");
    rd_ph(32'hA000_0007, 1'b0, "R5");
    chk("R10", {stop_n, trdy_n, devsel_n}, 3'b010);
    frame_n = 1'b1;
    @(negedge clk);
    end_chk("R10");

    // R4: write with master wait, garbage must not land
    addr_ph(4'h7, 1'b0, MB);
    irdy_n = 1'b1; ad_i = 32'hDEAD_DEAD; cbe_n = 4'h0;
    @(negedge clk);
    wr_ph(32'h55AA_55AA, 4'h0, 1'b1);
    end_chk("R6");
    addr_ph(4'h6, 1'b0, MB);
    @(negedge clk);
    rd_ph(32'h55AA_55AA, 1'b0, "R4");
    rd_ph(32'h1234_5678, 1'b1, "R4");
    end_chk("R6");

    // R7 R10: I/O burst past the I/O window
    addr_ph(4'h3, 1'b0, IB + 12);
    chk("R7", devsel_n, 0);
    wr_ph(32'h0BAD_F00D, 4'h0, 1'b0);
    chk("R10", {stop_n, trdy_n}, 2'b01);
    frame_n = 1'b1;
    @(negedge clk);
    end_chk("R10");
    addr_ph(4'h6, 1'b0, MB + 12);
    @(negedge clk);
    rd_ph(32'h0BAD_F00D, 1'b1, "R7");
    end_chk("R6");

    // R10: start beyond the array, write then read
    addr_ph(4'h7, 1'b0, MB + 36);
    chk("R10", {devsel_n, stop_n, trdy_n, ad_oe}, 4'b0010);
    frame_n = 1'b1; irdy_n = 1'b0;
    @(negedge clk);
    end_chk("R10");
    addr_ph(4'h6, 1'b0, MB + 40);
    chk("R10", {devsel_n, stop_n, trdy_n, ad_oe}, 4'b0010);
    frame_n = 1'b1; irdy_n = 1'b0;
    @(negedge clk);
    end_chk("R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule